// File: doc/BRIEF.md
# Thermal threshold interrupt controller

This block watches the 8-bit temperature code that an on-chip sensor delivers, one code per sample pulse. Software programs three rising thresholds and three falling thresholds, packed one per byte lane in two registers. Each sample is compared against every level. When the temperature moves upward across a rising level, or downward across a falling level, a sticky pending flag is set. Flags are masked by an enable register and combined into one interrupt line, and software clears them by writing ones.

A separate trip output does not depend on the interrupt logic. It is meant to drive an emergency shutdown path. It asserts whenever sensing is on, tripping is allowed and the held temperature is at or above the highest rising level. Registers are reached over a plain read/write bus with a word address.

Top module: `thermal_irq_ctrl`

## Requirements
- R1: Word addresses map as follows: 0 is control, 1 is rising thresholds, 2 is falling thresholds, 3 is interrupt enable, 4 is interrupt clear (write-only, reads 0) and 5 is temperature. Read data appears on `rdata` one clock after `rd_en`. After reset every register reads 0, and `irq` and `trip` are 0.
- R2: Control keeps only these bits: bit 0 (sensing on), bits 11:8 (tuning A), bit 12 (trip allowed), bits 23:20 (sensor select) and bits 28:24 (tuning B). All other bits read 0, so writing all ones reads back 0x1FF01F01.
- R3: Both threshold registers place level 0 in bits 15:8, level 1 in bits 23:16 and level 2 in bits 31:24. Bits 7:0 always read 0.
- R4: In the enable register, the rising enables for levels 0, 1 and 2 sit at bits 0, 4 and 8, and the falling enables sit at bits 16, 20 and 24. Other bits read 0.
- R5: A cycle with `code_valid` high while sensing is on loads `code` into the temperature register, which reads in bits 7:0. Otherwise the register holds its value.
- R6: A rising flag for a level is set by a sample that is at or above that level's rising threshold when the held temperature was below it. The flag stays set until it is cleared.
- R7: A falling flag for a level is set by a sample below that level's falling threshold when the held temperature was at or above it. A falling threshold of zero never sets its flag.
- R8: Writing the clear register clears each flag whose enable-register bit position holds a 1. Zeros leave flags untouched. A detection in the same cycle as a clear of the same flag wins.
- R9: `irq` is the OR over all flags of flag AND enable. It reflects a new flag in the cycle after the sample, and an already-pending flag as soon as its enable is set.
- R10: `trip` is high exactly when sensing is on, tripping is allowed and the held temperature is at or above the level-2 rising threshold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_en | input | 1 | Register write strobe |
| rd_en | input | 1 | Register read strobe |
| addr | input | ADDR_W | Word address |
| wdata | input | 32 | Write data |
| rdata | output | 32 | Read data, valid one clock after `rd_en` |
| code_valid | input | 1 | Sensor sample strobe |
| code | input | 8 | Raw sensor temperature code |
| irq | output | 1 | Masked interrupt request |
| trip | output | 1 | Hardware thermal trip |

## Verification
The bench builds the block with the default `ADDR_W` of 3, which decodes all six registers and leaves two spare addresses. A table drives a temperature walk through the thresholds 50/80/100 rising and 40/70/0 falling. The walk hits exact-equality boundaries, multi-level jumps in both directions, and a level whose falling threshold is zero. Directed steps then check the masking order, partial clears, clear-versus-detect in one cycle, and trip gating by each control bit.

// File: rtl/thermal_irq_ctrl.sv
module thermal_irq_ctrl #(
  parameter int ADDR_W = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [31:0]       wdata,
  output logic [31:0]       rdata,
  input  logic              code_valid,
  input  logic [7:0]        code,
  output logic              irq,
  output logic              trip
);
  localparam int LVLS = 3;
  localparam int FLAGS = 2 * LVLS;
  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(0);
  localparam logic [ADDR_W-1:0] A_RISE = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] A_FALL = ADDR_W'(2);
  localparam logic [ADDR_W-1:0] A_EN   = ADDR_W'(3);
  localparam logic [ADDR_W-1:0] A_CLR  = ADDR_W'(4);
  localparam logic [ADDR_W-1:0] A_TEMP = ADDR_W'(5);
  localparam logic [31:0] CTRL_MASK = 32'h1FF0_1F01;
  localparam logic [31:0] THR_MASK  = 32'hFFFF_FF00;
  localparam logic [31:0] EN_MASK   = 32'h0111_0111;

  logic [31:0] ctrl_q, rise_q, fall_q, en_q;
  logic [7:0]  temp_q;
  logic [FLAGS-1:0] pend_q, hit, en_v, clr_v;

  wire core_en = ctrl_q[0];
  wire trip_en = ctrl_q[12];
  wire smp     = code_valid & core_en;
  wire clr_wr  = wr_en && (addr == A_CLR);

  genvar i;
  generate
    for (i = 0; i < LVLS; i++) begin : g_lvl
      wire [7:0] thr_r = rise_q[8*i+15 -: 8];
      wire [7:0] thr_f = fall_q[8*i+15 -: 8];
      assign hit[i]        = smp && (temp_q < thr_r) && (code >= thr_r);
      assign hit[i+LVLS]   = smp && (thr_f != 8'd0) && (temp_q >= thr_f) && (code < thr_f);
      assign en_v[i]       = en_q[4*i];
      assign en_v[i+LVLS]  = en_q[16+4*i];
      assign clr_v[i]      = clr_wr & wdata[4*i];
      assign clr_v[i+LVLS] = clr_wr & wdata[16+4*i];

      AST_FALL_ZERO_OFF: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[i+LVLS]) |-> $past(thr_f != 8'd0)); // R7
    end
    for (i = 0; i < FLAGS; i++) begin : g_flag
      AST_FLAG_NEEDS_SAMPLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(pend_q[i]) |-> $past(smp)); // R5
      AST_HIT_LATCHES: assert property (@(posedge clk) disable iff (!rst_n)
        hit[i] |=> pend_q[i]); // R6
      AST_FALL_NEEDS_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(pend_q[i]) |-> $past(clr_v[i])); // R8
    end
  endgenerate

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      rise_q <= '0;
      fall_q <= '0;
      en_q   <= '0;
      temp_q <= '0;
      pend_q <= '0;
      rdata  <= '0;
    end else begin
      if (wr_en) begin
        case (addr)
          A_CTRL:  ctrl_q <= wdata & CTRL_MASK;
          A_RISE:  rise_q <= wdata & THR_MASK;
          A_FALL:  fall_q <= wdata & THR_MASK;
          A_EN:    en_q   <= wdata & EN_MASK;
          default: ;
        endcase
      end
      if (smp) temp_q <= code;
      pend_q <= (pend_q & ~clr_v) | hit;
      if (rd_en) begin
        case (addr)
          A_CTRL:  rdata <= ctrl_q;
          A_RISE:  rdata <= rise_q;
          A_FALL:  rdata <= fall_q;
          A_EN:    rdata <= en_q;
          A_TEMP:  rdata <= {24'd0, temp_q};
          default: rdata <= '0;
        endcase
      end
    end
  end

  assign irq  = |(pend_q & en_v);
  assign trip = core_en & trip_en & (temp_q >= rise_q[31:24]);

  AST_TEMP_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !smp |=> $stable(temp_q)); // R5
endmodule

// File: tb/tb_thermal_irq_ctrl.sv
`timescale 1ns/1ps
module tb_thermal_irq_ctrl;
  logic clk = 1'b0, rst_n = 1'b0, wr_en = 1'b0, rd_en = 1'b0, code_valid = 1'b0;
  logic [2:0] addr = '0;
  logic [31:0] wdata = '0, rdata;
  logic [7:0] code = '0;
  logic irq, trip;
  int checks = 0, fails = 0;
  bit done = 1'b0;

  thermal_irq_ctrl #(.ADDR_W(3)) dut (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .rdata(rdata), .code_valid(code_valid), .code(code),
    .irq(irq), .trip(trip));

  always #5 clk = ~clk;

  // {code, expected irq, expected trip}; rising 50/80/100, falling 40/70/off
  localparam int NV = 14;
  localparam logic [9:0] VEC [NV] = '{
    {8'd30, 1'b0, 1'b0}, {8'd55, 1'b1, 1'b0}, {8'd90, 1'b1, 1'b0},
    {8'd105, 1'b1, 1'b1}, {8'd99, 1'b0, 1'b0}, {8'd60, 1'b1, 1'b0},
    {8'd60, 1'b0, 1'b0}, {8'd35, 1'b1, 1'b0}, {8'd120, 1'b1, 1'b1},
    {8'd10, 1'b1, 1'b0}, {8'd49, 1'b0, 1'b0}, {8'd50, 1'b1, 1'b0},
    {8'd40, 1'b0, 1'b0}, {8'd39, 1'b1, 1'b0}};

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk);
    wr_en = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d);
    rd_en = 1'b1; addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rdata;
  endtask

  task automatic smp(input logic [7:0] c);
    code_valid = 1'b1; code = c;
    @(negedge clk);
    code_valid = 1'b0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got timeout expected completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 irq after reset", {31'd0, irq}, 32'd0);
    chk("R1 trip after reset", {31'd0, trip}, 32'd0);
    rd(3'd0, d); chk("R1 control reset", d, 32'd0);
    rd(3'd5, d); chk("R1 temperature reset", d, 32'd0);

    wr(3'd0, 32'hFFFF_FFFF); rd(3'd0, d); chk("R2 control mask", d, 32'h1FF0_1F01);
    wr(3'd0, 32'd0); smp(8'd77); rd(3'd5, d); chk("R5 sample ignored when off", d, 32'd0);
    wr(3'd1, 32'hFFFF_FFFF); rd(3'd1, d); chk("R3 rising layout", d, 32'hFFFF_FF00);
    wr(3'd2, 32'h1234_5678); rd(3'd2, d); chk("R3 falling layout", d, 32'h1234_5600);
    wr(3'd3, 32'hFFFF_FFFF); rd(3'd3, d); chk("R4 enable bits", d, 32'h0111_0111);
    rd(3'd4, d); chk("R1 clear reads zero", d, 32'd0);

    wr(3'd1, 32'h6450_3200);
    wr(3'd2, 32'h0046_2800);
    wr(3'd0, 32'h0000_1001);
    for (int k = 0; k < NV; k++) begin
      wr(3'd4, 32'h0111_0111);
      smp(VEC[k][9:2]);
      chk($sformatf("R6 R7 R9 irq step %0d", k), {31'd0, irq}, {31'd0, VEC[k][1]});
      chk($sformatf("R10 trip step %0d", k), {31'd0, trip}, {31'd0, VEC[k][0]});
      rd(3'd5, d); chk($sformatf("R5 temperature step %0d", k), d, {24'd0, VEC[k][9:2]});
    end

    wr(3'd3, 32'h0100_0000);
    wr(3'd4, 32'h0111_0111);
    smp(8'd120);
    chk("R9 rising flags masked", {31'd0, irq}, 32'd0);
    smp(8'd10);
    chk("R7 zero falling threshold off", {31'd0, irq}, 32'd0);
    wr(3'd3, 32'h0111_0111);
    chk("R9 pending shown on enable", {31'd0, irq}, 32'd1);

    wr(3'd4, 32'h0111_0111);
    wr(3'd3, 32'h0000_0010);
    smp(8'd90);
    chk("R6 level1 rising", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0000_0001);
    chk("R8 other clear bit keeps flag", {31'd0, irq}, 32'd1);
    wr(3'd4, 32'h0000_0010);
    chk("R8 clear bit drops flag", {31'd0, irq}, 32'd0);
    smp(8'd10);
    wr_en = 1'b1; addr = 3'd4; wdata = 32'h0000_0010;
    code_valid = 1'b1; code = 8'd90;
    @(negedge clk);
    wr_en = 1'b0; code_valid = 1'b0;
    chk("R8 detection beats clear", {31'd0, irq}, 32'd1);

    smp(8'd110);
    chk("R10 trip when hot", {31'd0, trip}, 32'd1);
    wr(3'd0, 32'h0000_0001);
    chk("R10 trip disallowed", {31'd0, trip}, 32'd0);
    wr(3'd0, 32'h0000_1000);
    chk("R10 sensing off", {31'd0, trip}, 32'd0);
    smp(8'd20);
    rd(3'd5, d); chk("R5 hold while off", d, 32'd110);

    done = 1'b1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule